// File: doc/BRIEF.md
# Dual-Address Normal-Mode DMA Channel

This block is one DMA channel that copies data between two memory locations on request. Software loads a 24-bit source pointer, a 24-bit destination pointer, a 16-bit transfer count and a control word. Each pulse on the request input then moves one byte or one 16-bit word. The move is a read cycle from the source pointer followed by a write cycle of the captured data to the destination pointer. After each move, both pointers step and the count drops by one.

Each pointer is configured on its own to count up, count down or stay put. The step is 1 for bytes and 2 for words, and the arithmetic wraps modulo 2^24. When the count falls to zero, the channel clears its own enable. If the end-interrupt enable is set, it also raises a sticky interrupt request, which stays high until software clears it or re-enables the channel. Loading a count of zero gives 65,536 moves. The memory side is a request/ready handshake, and memory answers in one cycle.

Top module: `dma_chan`

## Requirements
- R1: After reset, both pointers and the count read 0, and the channel enable, the interrupt, `memReq` and `busy` are all 0.
- R2: Moves occur only when control bit 1 (full-address enable) is 1 and control bit 2 (block enable) is 0. With any other setting, a request causes no memory cycle and leaves the pointers and the count unchanged.
- R3: A request moves exactly one item. It is a read at the source pointer (`memWe`=0), then a write of the read data to the destination pointer (`memWe`=1). Control bit 4 selects the size: 1 for a 16-bit word, stored little-endian, and 0 for a byte.
- R4: Once the move completes, each pointer steps according to its own 2-bit mode. The source mode is control bits 6:5 and the destination mode is bits 8:7. Mode 01 adds the step, mode 10 subtracts it, and modes 00 and 11 leave the pointer unchanged. The step is 1 for bytes and 2 for words.
- R5: Pointer arithmetic wraps modulo 2^24.
- R6: The count decrements by one per completed move. When it reaches 0, the channel enable (control bit 0) clears, and later requests cause no memory cycle.
- R7: A starting count of 0 is treated as 65,536. After one move it reads 0xFFFF and the channel stays enabled.
- R8: When a move ends the run and control bit 3 (end-interrupt enable) is 1, `irq` rises. It stays high until a control write sets bit 9, or until a control write re-enables a disabled channel. If bit 3 is 0, `irq` stays low.
- R9: A request that arrives while a move is in progress is held pending and served afterwards. A request that arrives while the channel is disabled is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| regWdata | input | 24 | Register write data |
| xferReq | input | 1 | Transfer request pulse |
| srcAddr | output | 24 | Current source pointer |
| dstAddr | output | 24 | Current destination pointer |
| count | output | 16 | Remaining transfer count |
| chanEn | output | 1 | Channel enable (control bit 0) |
| busy | output | 1 | A move is in progress |
| irq | output | 1 | Transfer-end interrupt request |
| memReq | output | 1 | Memory cycle request |
| memWe | output | 1 | 1 for a write cycle, 0 for a read cycle |
| memWord | output | 1 | 1 for a 16-bit cycle, 0 for a byte cycle |
| memAddr | output | 24 | Memory address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data |
| memReady | input | 1 | Memory cycle complete |

## Verification
The bench checks the case where a pointer wraps past either end of the 24-bit space. A design that does not wrap would carry into a bit that does not exist or would leave the pointer stuck. It checks a count of zero: a design that tests for zero before decrementing would end the run at once, with no move. It checks requests sent back to back during a move: a design that drops the second request would come up one move short. It also checks the completion rules, namely that the enable self-clears, that `irq` is sticky and that the interrupt-enable gating works, and it confirms that the mode gate really blocks memory cycles rather than only freezing the count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch read data into the buffer
    logic advance;  // step pointers, decrement count
  } dpStrobe_t;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam logic [1:0] MODE_UP   = 2'b01;
  localparam logic [1:0] MODE_DOWN = 2'b10;

  localparam int CTRL_W = 10;
endpackage

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  dpStrobe_t         strobe,
  input  logic              wordSize,
  input  logic [1:0]        srcMode,
  input  logic [1:0]        dstMode,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] dataBuf,
  output logic              countIsOne
);
  localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  logic [ADDR_W-1:0] stepLen;
  logic [ADDR_W-1:0] srcNext, dstNext;

  assign stepLen = wordSize ? STEP_WORD : STEP_BYTE;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] ptr,
                                                input logic [1:0] mode,
                                                input logic [ADDR_W-1:0] len);
    case (mode)
      MODE_UP:   return ptr + len;
      MODE_DOWN: return ptr - len;
      default:   return ptr;
    endcase
  endfunction

  assign srcNext    = nextPtr(srcAddr, srcMode, stepLen);
  assign dstNext    = nextPtr(dstAddr, dstMode, stepLen);
  assign countIsOne = (count == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      count   <= '0;
      dataBuf <= '0;
    end else begin
      if (strobe.capture) dataBuf <= memRdata;
      if (strobe.advance) begin
        srcAddr <= srcNext;
        dstAddr <= dstNext;
        count   <= count - CNT_ONE;
      end else if (regWe) begin
        case (regSel)
          SEL_SRC: srcAddr <= regWdata;
          SEL_DST: dstAddr <= regWdata;
          SEL_CNT: count   <= regWdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // R6: one decrement per completed move, wrapping 0 -> all ones (R7)
  a_r6_count_dec: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> count == $past(count) - CNT_ONE);

  // R4: a pointer in a hold mode keeps its value across a move
  a_r4_src_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && srcMode != MODE_UP && srcMode != MODE_DOWN) |=> $stable(srcAddr));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              xferReq,
  input  logic              memReady,
  input  logic              countIsOne,
  output dpStrobe_t         strobe,
  output logic              chanEn,
  output logic              wordSize,
  output logic [1:0]        srcMode,
  output logic [1:0]        dstMode,
  output logic              irq,
  output logic              busy,
  output logic              memReq,
  output logic              memWe
);
  chanState_t state, stateNext;
  logic fullEn, blkEn, irqEn, pend;
  logic active, take, done, ctrlWr;

  assign active = chanEn && fullEn && !blkEn;
  assign take   = (state == ST_IDLE) && pend && active;
  assign done   = (state == ST_WRITE) && memReady && countIsOne;
  assign ctrlWr = regWe && (regSel == SEL_CTRL);

  assign strobe.capture = (state == ST_READ) && memReady;
  assign strobe.advance = (state == ST_WRITE) && memReady;
  assign memReq = (state != ST_IDLE);
  assign memWe  = (state == ST_WRITE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (take) stateNext = ST_READ;
      ST_READ:  if (memReady) stateNext = ST_WRITE;
      ST_WRITE: if (memReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      chanEn   <= 1'b0;
      fullEn   <= 1'b0;
      blkEn    <= 1'b0;
      irqEn    <= 1'b0;
      wordSize <= 1'b0;
      srcMode  <= 2'b00;
      dstMode  <= 2'b00;
      irq      <= 1'b0;
      pend     <= 1'b0;
    end else begin
      state <= stateNext;
      pend  <= active && ((pend && !take) || xferReq);
      if (ctrlWr) begin
        chanEn   <= ctrlWdata[0];
        fullEn   <= ctrlWdata[1];
        blkEn    <= ctrlWdata[2];
        irqEn    <= ctrlWdata[3];
        wordSize <= ctrlWdata[4];
        srcMode  <= ctrlWdata[6:5];
        dstMode  <= ctrlWdata[8:7];
        if (ctrlWdata[9] || (ctrlWdata[0] && !chanEn)) irq <= 1'b0;
      end
      if (done) begin
        chanEn <= 1'b0;
        if (irqEn) irq <= 1'b1;
      end
    end
  end

  // R6: the last move clears the enable
  a_r6_done_clears_en: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && countIsOne) |=> !chanEn);

  // R8: the last move raises irq when enabled
  a_r8_irq_on_end: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && countIsOne && irqEn) |=> irq);

  // R2: an inactive channel never starts a move
  a_r2_inactive_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && !active) |=> !memReq);

  // R3: a completed read is always followed by a write
  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memReady) |=> (memReq && memWe));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              xferReq,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  count,
  output logic              chanEn,
  output logic              busy,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic              memWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady
);
  dpStrobe_t  strobe;
  logic       countIsOne;
  logic [1:0] srcMode, dstMode;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .ctrlWdata(regWdata[CTRL_W-1:0]), .xferReq(xferReq), .memReady(memReady),
    .countIsOne(countIsOne), .strobe(strobe), .chanEn(chanEn),
    .wordSize(memWord), .srcMode(srcMode), .dstMode(dstMode), .irq(irq),
    .busy(busy), .memReq(memReq), .memWe(memWe)
  );

  dma_chan_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .strobe(strobe), .wordSize(memWord), .srcMode(srcMode), .dstMode(dstMode),
    .memRdata(memRdata), .srcAddr(srcAddr), .dstAddr(dstAddr), .count(count),
    .dataBuf(memWdata), .countIsOne(countIsOne)
  );

  assign memAddr = memWe ? dstAddr : srcAddr;
endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [23:0] regWdata = '0;
  logic        xferReq = 1'b0;
  logic [23:0] srcAddr, dstAddr, memAddr;
  logic [15:0] count, memWdata, memRdata;
  logic        chanEn, busy, irq, memReq, memWe, memWord, memReady;

  logic [7:0]  mem [256];
  int          memCycles = 0;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  dma_chan u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .xferReq(xferReq), .srcAddr(srcAddr), .dstAddr(dstAddr), .count(count),
    .chanEn(chanEn), .busy(busy), .irq(irq), .memReq(memReq), .memWe(memWe),
    .memWord(memWord), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  // one-cycle memory, byte array indexed by the low address byte
  assign memReady = memReq;
  assign memRdata = {mem[8'(memAddr[7:0] + 8'd1)], mem[memAddr[7:0]]};

  always @(posedge clk) begin
    if (memReq && memReady) memCycles <= memCycles + 1;
    if (memReq && memReady && memWe) begin
      mem[memAddr[7:0]] <= memWdata[7:0];
      if (memWord) mem[8'(memAddr[7:0] + 8'd1)] <= memWdata[15:8];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [23:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // ctrl word: en|fae<<1|blk<<2|ie<<3|word<<4|sm<<5|dm<<7|clr<<9
  function automatic logic [23:0] ctl(input bit en, input bit fae, input bit blk,
                                      input bit ie, input bit word,
                                      input logic [1:0] sm, input logic [1:0] dm,
                                      input bit clr);
    return {14'd0, clr, dm, sm, word, ie, blk, fae, en};
  endfunction

  task automatic pulse();
    @(negedge clk); xferReq = 1'b1;
    @(negedge clk); xferReq = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 src", srcAddr, 0);
    check("R1 dst", dstAddr, 0);
    check("R1 count", count, 0);
    check("R1 en/irq/req/busy", {chanEn, irq, memReq, busy}, 0);
  endtask

  task automatic t_byte_up();
    mem[8'h10] = 8'hA5; mem[8'h40] = 8'h00;
    wr(2'd0, 24'h000010); wr(2'd1, 24'h000040); wr(2'd2, 24'd3);
    wr(2'd3, ctl(1, 1, 0, 1, 0, 2'b01, 2'b01, 0));
    memCycles = 0;
    pulse(); settle();
    check("R3 byte copied", mem[8'h40], 8'hA5);
    check("R3 two cycles", memCycles, 2);
    check("R4 src +1", srcAddr, 24'h000011);
    check("R4 dst +1", dstAddr, 24'h000041);
    check("R6 count 3->2", count, 2);
  endtask

  task automatic t_word_mixed();
    mem[8'h20] = 8'h34; mem[8'h21] = 8'h12; mem[8'h80] = 0; mem[8'h81] = 0;
    wr(2'd0, 24'h000020); wr(2'd1, 24'h000080); wr(2'd2, 24'd5);
    wr(2'd3, ctl(1, 1, 0, 0, 1, 2'b01, 2'b10, 0));
    pulse(); settle();
    check("R3 word low", mem[8'h80], 8'h34);
    check("R3 word high", mem[8'h81], 8'h12);
    check("R4 src +2", srcAddr, 24'h000022);
    check("R4 dst -2", dstAddr, 24'h00007E);
  endtask

  task automatic t_hold();
    mem[8'h30] = 8'h5C;
    wr(2'd0, 24'h000030); wr(2'd1, 24'h000050); wr(2'd2, 24'd5);
    wr(2'd3, ctl(1, 1, 0, 0, 0, 2'b11, 2'b00, 0));
    pulse(); settle();
    check("R4 src hold 11", srcAddr, 24'h000030);
    check("R4 dst hold 00", dstAddr, 24'h000050);
    check("R3 data held-mode", mem[8'h50], 8'h5C);
  endtask

  task automatic t_wrap();
    wr(2'd0, 24'hFFFFFF); wr(2'd1, 24'h000000); wr(2'd2, 24'd5);
    wr(2'd3, ctl(1, 1, 0, 0, 0, 2'b01, 2'b10, 0));
    pulse(); settle();
    check("R5 src wraps up", srcAddr, 24'h000000);
    check("R5 dst wraps down", dstAddr, 24'hFFFFFF);
  endtask

  task automatic t_complete();
    wr(2'd0, 24'h000010); wr(2'd1, 24'h000060); wr(2'd2, 24'd2);
    wr(2'd3, ctl(1, 1, 0, 1, 0, 2'b01, 2'b01, 0));
    pulse(); settle();
    check("R6 count 1", count, 1);
    check("R8 no irq mid-run", {chanEn, irq}, 2'b10);
    pulse(); settle();
    check("R6 count 0", count, 0);
    check("R6 enable self-clears", chanEn, 0);
    check("R8 irq raised", irq, 1);
    memCycles = 0;
    pulse(); settle();
    check("R9 disabled req ignored", memCycles, 0);
    check("R6 src unchanged after end", srcAddr, 24'h000012);
    check("R8 irq sticky", irq, 1);
    wr(2'd3, ctl(0, 1, 0, 1, 0, 2'b01, 2'b01, 1));
    check("R8 irq cleared by bit9", irq, 0);
  endtask

  task automatic t_reenable_clears();
    wr(2'd2, 24'd1);
    wr(2'd3, ctl(1, 1, 0, 1, 0, 2'b01, 2'b01, 0));
    pulse(); settle();
    check("R8 irq after 1-count run", irq, 1);
    wr(2'd2, 24'd4);
    wr(2'd3, ctl(1, 1, 0, 1, 0, 2'b01, 2'b01, 0));
    check("R8 irq cleared by re-enable", irq, 0);
  endtask

  task automatic t_no_irq();
    wr(2'd2, 24'd1);
    wr(2'd3, ctl(1, 1, 0, 0, 0, 2'b01, 2'b01, 0));
    pulse(); settle();
    check("R8 no irq when disabled", {chanEn, irq}, 2'b00);
  endtask

  task automatic t_gate();
    wr(2'd0, 24'h000010); wr(2'd2, 24'd7);
    wr(2'd3, ctl(1, 0, 0, 0, 0, 2'b01, 2'b01, 0));
    memCycles = 0;
    pulse(); settle();
    check("R2 fae=0 no cycles", memCycles, 0);
    check("R2 fae=0 count kept", count, 7);
    wr(2'd3, ctl(1, 1, 1, 0, 0, 2'b01, 2'b01, 0));
    pulse(); settle();
    check("R2 blk=1 no cycles", memCycles, 0);
    check("R2 blk=1 src kept", srcAddr, 24'h000010);
  endtask

  task automatic t_zero_count();
    wr(2'd2, 24'd0);
    wr(2'd3, ctl(1, 1, 0, 1, 0, 2'b01, 2'b01, 0));
    pulse(); settle();
    check("R7 count wraps to FFFF", count, 16'hFFFF);
    check("R7 still enabled", {chanEn, irq}, 2'b10);
  endtask

  task automatic t_pending();
    wr(2'd2, 24'd10);
    wr(2'd0, 24'h000010);
    wr(2'd3, ctl(1, 1, 0, 0, 0, 2'b01, 2'b01, 0));
    memCycles = 0;
    pulse(); pulse();
    repeat (14) @(negedge clk);
    check("R9 both requests served", count, 8);
    check("R9 four cycles", memCycles, 4);
    check("R9 src +2", srcAddr, 24'h000012);
  endtask

  initial begin
    #500_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_byte_up();
    t_word_mixed();
    t_hold();
    t_wrap();
    t_complete();
    t_reenable_clears();
    t_no_irq();
    t_gate();
    t_zero_count();
    t_pending();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule